// File: doc/BRIEF.md
# Edge-Sensitive DMA Request Front End

This block is the request side of one DMA channel running in edge-sensitive mode. It registers the external request line on every rising clock edge. A request counts only when the line has just moved to its active level. A configuration bit chooses whether a rising or a falling transition is the active one. When an edge arrives while the channel is idle, the channel claims the bus and starts a data transfer. The size field in force at that moment is captured with the transfer.

The bus side reports the end of each data transfer with an acknowledge pulse. That pulse is the decision point. If an edge has been seen since the previous decision, including at the decision clock itself, the channel chains straight into the next transfer. A higher-priority channel that is waiting makes it yield instead, and the request is kept for later. With no edge seen, the channel releases the bus and goes idle. The DMA acknowledge output follows the chosen polarity: it is active high for rising-edge requests and active low for falling-edge requests.

Top module: `dma_edge_req`

## Requirements
- R1: A valid edge occurs at a clock edge where `dma_req_in` is at its active level and its sample from the previous clock was not. The active level is 1 when `cfg_rise_edge`=1 and 0 when `cfg_rise_edge`=0. A transition toward the inactive level never requests a transfer.
- R2: In the idle state, a valid edge or a held pending request, with `hi_prio_pend`=0, has the following effect after that clock: `bus_req`=1, `xfer_start` pulses high for one cycle, and `xfer_len` holds the `cfg_xfer_size` value sampled at that clock.
- R3: `dma_ack` equals `cfg_rise_edge` while `bus_req`=1 and equals its complement while `bus_req`=0.
- R4: In the transfer state the channel stays there until `xfer_ack`=1. At an `xfer_ack` clock with a request seen and `hi_prio_pend`=0, the channel stays in the transfer state, pulses `xfer_start` in the next cycle, reloads `xfer_len`, and does not pulse `bus_release`.
- R5: At an `xfer_ack` clock with a request seen and `hi_prio_pend`=1, the channel drops `bus_req` and pulses `bus_release`, and it keeps the request. It restarts in the cycle after the first clock at which `hi_prio_pend`=0.
- R6: At an `xfer_ack` clock with no request seen, the channel drops `bus_req` in the next cycle and pulses `bus_release` high for exactly one cycle.
- R7: Any number of valid edges between two decision points yields exactly one transfer. Each accepted request clears the pending state.
- R8: While `rst_n`=0 and after its release, `bus_req`, `xfer_start` and `bus_release` are 0 and `dma_ack` is at its inactive level. A level that is already active when reset is released does not count as an edge.
- R9: `xfer_ack` has no effect while the channel is idle.
- R10: A request line held at its active level produces no further transfers after the one for its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_rise_edge | input | 1 | 1: rising transition requests; 0: falling transition requests |
| cfg_xfer_size | input | SZ_W | Transfer size code captured per accepted request |
| dma_req_in | input | 1 | External DMA request line |
| xfer_ack | input | 1 | End-of-data-transfer acknowledge from the bus side |
| hi_prio_pend | input | 1 | A higher-priority channel has a pending request |
| bus_req | output | 1 | Bus ownership requested (transfer state) |
| bus_release | output | 1 | One-cycle pulse when the channel returns to idle |
| xfer_start | output | 1 | One-cycle pulse at the start of each data transfer |
| xfer_len | output | SZ_W | Size code of the transfer in progress |
| dma_ack | output | 1 | DMA acknowledge, polarity set by cfg_rise_edge |

## Verification
Every cycle, the assertions check the properties that relate outputs to each other. A rise of `bus_req` comes with a start pulse. The transfer state persists without an acknowledge. A release pulse lasts one cycle and comes after a held bus. A chained start needs an acknowledge. A yield follows a decision taken under higher priority. The idle polarity of `dma_ack` is checked as well. Only the bench's scenarios can show the edge semantics: that edges collapse into one transfer and that a held level stays silent. The same applies to keeping the request across a yield, to ignoring the first sample after reset, and to capturing the size. The bench compares these against a reference stepped over long pseudo-random sequences in both polarities.

// File: rtl/dma_edge_pkg.sv
package dma_edge_pkg;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_XFER = 1'b1
  } ch_state_e;

endpackage

// File: rtl/dma_edge_detect.sv
module dma_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_sel,
  input  logic req_in,
  output logic edge_hit
);

  logic smp_q;
  logic primed_q;
  logic lvl_now;
  logic lvl_prev;

  // active level of the current line value and of the previous sample
  always_comb begin
    lvl_now  = rise_sel ? req_in : ~req_in;
    lvl_prev = rise_sel ? smp_q  : ~smp_q;
    edge_hit = primed_q & lvl_now & ~lvl_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      smp_q    <= req_in;
      primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_edge_pend.sv
module dma_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hit,
  input  logic consume,
  output logic req_any
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    req_any = edge_hit | pend_q;
    pend_d  = consume ? 1'b0 : req_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/dma_edge_fsm.sv
module dma_edge_fsm
  import dma_edge_pkg::*;
#(
  parameter int SZ_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_any,
  input  logic            xfer_ack,
  input  logic            hi_prio,
  input  logic [SZ_W-1:0] size_in,
  output logic            consume,
  output logic            bus_req,
  output logic            start_pls,
  output logic            rel_pls,
  output logic [SZ_W-1:0] len_out
);

  ch_state_e       st_q, st_d;
  logic            start_q, start_d;
  logic            rel_q, rel_d;
  logic [SZ_W-1:0] len_q;
  logic            len_en;
  logic            go;

  always_comb begin
    go      = req_any & ~hi_prio;
    st_d    = st_q;
    start_d = 1'b0;
    rel_d   = 1'b0;
    consume = 1'b0;
    case (st_q)
      CH_IDLE: begin
        if (go) begin
          st_d    = CH_XFER;
          start_d = 1'b1;
          consume = 1'b1;
        end
      end
      CH_XFER: begin
        if (xfer_ack) begin
          if (go) begin
            start_d = 1'b1;
            consume = 1'b1;
          end else begin
            st_d  = CH_IDLE;
            rel_d = 1'b1;
          end
        end
      end
      default: st_d = CH_IDLE;
    endcase
    len_en = start_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_IDLE;
      start_q <= 1'b0;
      rel_q   <= 1'b0;
      len_q   <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      rel_q   <= rel_d;
      if (len_en) len_q <= size_in;
    end
  end

  always_comb begin
    bus_req   = (st_q == CH_XFER);
    start_pls = start_q;
    rel_pls   = rel_q;
    len_out   = len_q;
  end

endmodule

// File: rtl/dma_edge_req.sv
module dma_edge_req #(
  parameter int SZ_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_rise_edge,
  input  logic [SZ_W-1:0] cfg_xfer_size,
  input  logic            dma_req_in,
  input  logic            xfer_ack,
  input  logic            hi_prio_pend,
  output logic            bus_req,
  output logic            bus_release,
  output logic            xfer_start,
  output logic [SZ_W-1:0] xfer_len,
  output logic            dma_ack
);

  logic edge_hit;
  logic req_any;
  logic consume;

  dma_edge_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_sel (cfg_rise_edge),
    .req_in   (dma_req_in),
    .edge_hit (edge_hit)
  );

  dma_edge_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_hit (edge_hit),
    .consume  (consume),
    .req_any  (req_any)
  );

  dma_edge_fsm #(.SZ_W(SZ_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_any   (req_any),
    .xfer_ack  (xfer_ack),
    .hi_prio   (hi_prio_pend),
    .size_in   (cfg_xfer_size),
    .consume   (consume),
    .bus_req   (bus_req),
    .start_pls (xfer_start),
    .rel_pls   (bus_release),
    .len_out   (xfer_len)
  );

  // acknowledge polarity follows the selected request edge
  always_comb dma_ack = cfg_rise_edge ? bus_req : ~bus_req;

endmodule

// File: rtl/dma_edge_req_chk.sv
module dma_edge_req_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rise_edge,
  input logic xfer_ack,
  input logic hi_prio_pend,
  input logic bus_req,
  input logic bus_release,
  input logic xfer_start,
  input logic dma_ack
);

  AST_ROSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> xfer_start); // R2

  AST_START_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> bus_req); // R2

  AST_IDLE_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (dma_ack != cfg_rise_edge)); // R3

  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !xfer_ack) |=> bus_req); // R4

  AST_CHAIN_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && $past(bus_req)) |-> $past(xfer_ack)); // R4

  AST_YIELD_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req) && $past(xfer_ack) && $past(hi_prio_pend)) |-> !bus_req); // R5

  AST_REL_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> (!bus_req && $past(bus_req))); // R6

  AST_REL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_release); // R6

endmodule

bind dma_edge_req dma_edge_req_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rise_edge (cfg_rise_edge),
  .xfer_ack      (xfer_ack),
  .hi_prio_pend  (hi_prio_pend),
  .bus_req       (bus_req),
  .bus_release   (bus_release),
  .xfer_start    (xfer_start),
  .dma_ack       (dma_ack)
);

// File: tb/dma_edge_req_tb.sv
`timescale 1ns/1ps
module dma_edge_req_tb;

  localparam int SZ_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_rise_edge = 1'b1;
  logic [SZ_W-1:0] cfg_xfer_size = '0;
  logic            dma_req_in = 1'b0;
  logic            xfer_ack = 1'b0;
  logic            hi_prio_pend = 1'b0;
  logic            bus_req, bus_release, xfer_start, dma_ack;
  logic [SZ_W-1:0] xfer_len;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_edge_req #(.SZ_W(SZ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rise_edge(cfg_rise_edge),
    .cfg_xfer_size(cfg_xfer_size), .dma_req_in(dma_req_in),
    .xfer_ack(xfer_ack), .hi_prio_pend(hi_prio_pend),
    .bus_req(bus_req), .bus_release(bus_release), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .dma_ack(dma_ack)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic br, input logic st,
                         input logic rl);
    chk(bus_req == br, {tag, " bus_req"}, int'(bus_req), int'(br));
    chk(xfer_start == st, {tag, " xfer_start"}, int'(xfer_start), int'(st));
    chk(bus_release == rl, {tag, " bus_release"}, int'(bus_release), int'(rl));
  endtask

  // reference state, derived from the requirements
  logic            m_xfer, m_pend, m_prev, m_primed, m_start, m_rel;
  logic [SZ_W-1:0] m_len;

  task automatic m_reset();
    m_xfer = 0; m_pend = 0; m_prev = 0; m_primed = 0;
    m_start = 0; m_rel = 0; m_len = '0;
  endtask

  task automatic m_step();
    logic a_now, a_prev, e, rq;
    a_now  = cfg_rise_edge ? dma_req_in : !dma_req_in;
    a_prev = cfg_rise_edge ? m_prev : !m_prev;
    e  = m_primed && a_now && !a_prev;
    rq = e || m_pend;
    m_start = 0; m_rel = 0;
    if (!m_xfer) begin
      if (rq && !hi_prio_pend) begin
        m_xfer = 1; m_start = 1; m_len = cfg_xfer_size; m_pend = 0;
      end else m_pend = rq;
    end else if (xfer_ack) begin
      if (rq && !hi_prio_pend) begin
        m_start = 1; m_len = cfg_xfer_size; m_pend = 0;
      end else begin
        m_xfer = 0; m_rel = 1; m_pend = rq;
      end
    end else m_pend = rq;
    m_prev = dma_req_in;
    m_primed = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // ---------------- directed, rising-edge mode ----------------
    cfg_rise_edge = 1; cfg_xfer_size = 3'd5;
    do_reset();
    tick();
    chk_out("R8 reset", 0, 0, 0);
    chk(dma_ack == 0, "R8 reset dma_ack", int'(dma_ack), 0);

    xfer_ack = 1; tick(); tick();
    chk_out("R9 ack idle", 0, 0, 0);
    xfer_ack = 0;

    dma_req_in = 1; tick();
    chk_out("R2 start", 1, 1, 0);
    chk(dma_ack == 1, "R3 ack high", int'(dma_ack), 1);
    chk(xfer_len == 3'd5, "R2 len", int'(xfer_len), 5);
    cfg_xfer_size = 3'd2; tick();
    chk_out("R4 hold", 1, 0, 0);
    chk(xfer_len == 3'd5, "R2 len held", int'(xfer_len), 5);

    xfer_ack = 1; tick(); xfer_ack = 0;
    chk_out("R6 release", 0, 0, 1);
    chk(dma_ack == 0, "R3 ack idle", int'(dma_ack), 0);
    tick();
    chk_out("R6 pulse end", 0, 0, 0);
    tick(); tick();
    chk_out("R10 level held", 0, 0, 0);

    dma_req_in = 0; tick();
    dma_req_in = 1; tick();
    chk_out("R1 rise start", 1, 1, 0);
    chk(xfer_len == 3'd2, "R2 len new", int'(xfer_len), 2);
    dma_req_in = 0; tick(); dma_req_in = 1; tick();
    dma_req_in = 0; tick(); dma_req_in = 1; tick();
    xfer_ack = 1; tick();
    chk_out("R4 chain", 1, 1, 0);
    tick(); xfer_ack = 0;
    chk_out("R7 one transfer", 0, 0, 1);

    dma_req_in = 0; tick(); dma_req_in = 1; tick();
    chk_out("R5 setup", 1, 1, 0);
    dma_req_in = 0; tick(); dma_req_in = 1; tick();
    hi_prio_pend = 1; xfer_ack = 1; tick(); xfer_ack = 0;
    chk_out("R5 yield", 0, 0, 1);
    tick();
    chk_out("R5 wait hi", 0, 0, 0);
    hi_prio_pend = 0; tick();
    chk_out("R5 resume", 1, 1, 0);
    xfer_ack = 1; tick(); xfer_ack = 0;
    chk_out("R6 release2", 0, 0, 1);

    // level already active at reset release
    dma_req_in = 1;
    do_reset();
    tick(); tick();
    chk_out("R8 first sample", 0, 0, 0);

    // ---------------- directed, falling-edge mode ----------------
    @(negedge clk); rst_n = 0; cfg_rise_edge = 0; dma_req_in = 1; tick();
    chk(dma_ack == 1, "R8 falling reset dma_ack", int'(dma_ack), 1);
    rst_n = 1; tick();
    dma_req_in = 0; tick();
    chk_out("R1 fall start", 1, 1, 0);
    chk(dma_ack == 0, "R3 ack low", int'(dma_ack), 0);
    xfer_ack = 1; tick(); xfer_ack = 0;
    chk(dma_ack == 1, "R3 ack idle high", int'(dma_ack), 1);
    dma_req_in = 1; tick();
    chk_out("R1 rise ignored", 0, 0, 0);

    // ---------------- pseudo-random sweep, both polarities ----------------
    lfsr = 16'hACE1;
    for (int pol = 0; pol < 2; pol++) begin
      @(negedge clk);
      rst_n = 0; cfg_rise_edge = pol[0]; dma_req_in = 0; xfer_ack = 0;
      hi_prio_pend = 0;
      tick();
      m_reset();
      rst_n = 1;
      for (int cyc = 0; cyc < 3000; cyc++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[2:0] == 3'd0) dma_req_in = !dma_req_in;
        xfer_ack      = (lfsr[5:4] == 2'b11);
        hi_prio_pend  = (lfsr[9:7] == 3'b101);
        cfg_xfer_size = lfsr[12:10];
        tick();
        m_step();
        chk_out("R2 R4 R5 R6 R7 sweep", m_xfer, m_start, m_rel);
        chk(dma_ack == (m_xfer ? cfg_rise_edge : !cfg_rise_edge),
            "R3 sweep dma_ack", int'(dma_ack),
            int'(m_xfer ? cfg_rise_edge : !cfg_rise_edge));
        chk(xfer_len == m_len, "R2 sweep len", int'(xfer_len), int'(m_len));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule